// File: doc/BRIEF.md
# Serial Port Ready-Flag Controller

This block keeps the two handshake flags of a UART-style serial port and raises the two interrupt requests that go with them. The receive side holds a one-byte data register. The receive-ready flag marks that this register holds a byte software has not consumed yet. The transmit side holds a one-byte holding buffer. The transmit-ready flag marks that this buffer may take another byte. The bit-level shifters and baud timing sit outside the block. They reach it only as a byte-complete pulse with its byte, and as a shifter-idle level.

Software reaches the block through simple register strobes. It can write the transmit data register or the flag register. It can read the receive data, the flag register or the interrupt vector. Several side effects clear the flags: a receive-data read, a write-one to the flag bit, and three reset sources. Reading the interrupt vector is deliberately not one of them. When the shifter is idle and the buffer is full, the block hands the buffered byte to the shifter and frees the buffer again.

Top module: `serial_flag_ctrl`

## Requirements
- R1: A `rxByteDone` pulse loads `rxByteIn` into `rxData`, and `rxReady` reads 1 after that clock edge.
- R2: `rxReady` goes to 0 after the edge of a cycle that has any of these: `swReset`, `modReset`, `rdRxStb`, or `wrFlagStb` with `wrData[9]`=1.
- R3: A flag write with `wrData[9]`=0 leaves `rxReady` unchanged. A flag write changes no other state, and bit 8 in particular does not touch `txReady`.
- R4: When `rxByteDone` falls on the same cycle as a write-one clear or a receive-data read, `rxReady` ends up 1. When it falls on the same cycle as `swReset` or `modReset`, `rxReady` ends up 0.
- R5: `rdVecStb` captures a code into `vecRead` at the next edge: 1 while `rxIrq` is high, otherwise 2 while `txIrq` is high, otherwise 0. This read changes neither flag.
- R6: `rxIrq` equals `rxReady` AND `rxIntEn`.
- R7: `wrTxStb` stores `wrData[7:0]` in the holding buffer, and `txReady` reads 0 after that edge.
- R8: `txLoad` is high while `shifterIdle` is 1, `txReady` is 0 and `modReset` is 0. During that time `txShiftData` shows the buffered byte, and `txReady` becomes 1 at the edge. If `wrTxStb` falls on the same cycle, `txReady` stays 0 and the new byte is buffered.
- R9: System reset (`rstN` low) and `modReset` force `txReady` to 1, and `modReset` also wins over `wrTxStb`. `swReset` leaves `txReady` unchanged.
- R10: `txIrq` equals `txReady` AND `txIntEn` AND `txEnable`.
- R11: `rdFlagStb` captures the flags into `flagRead` at the next edge: bit 9 is `rxReady`, bit 8 is `txReady`, and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| swReset | input | 1 | Software reset, clears receive side |
| modReset | input | 1 | Module reset bit, clears receive, fills transmit-ready |
| txEnable | input | 1 | Transmitter enable, gates transmit interrupt |
| rxIntEn | input | 1 | Receive interrupt enable |
| txIntEn | input | 1 | Transmit interrupt enable |
| wrTxStb | input | 1 | Write strobe for transmit data register |
| wrFlagStb | input | 1 | Write strobe for flag register |
| wrData | input | 16 | Write data |
| rdRxStb | input | 1 | Read strobe for receive data register |
| rdVecStb | input | 1 | Read strobe for interrupt vector |
| rdFlagStb | input | 1 | Read strobe for flag register |
| rxByteDone | input | 1 | Receive shifter finished a byte |
| rxByteIn | input | 8 | Byte from receive shifter |
| shifterIdle | input | 1 | Transmit shifter can accept a byte |
| rxData | output | 8 | Receive data register |
| txShiftData | output | 8 | Buffered byte offered to transmit shifter |
| txLoad | output | 1 | Buffer-to-shifter copy this cycle |
| rxReady | output | 1 | Receive-ready flag |
| txReady | output | 1 | Transmit-ready flag |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| flagRead | output | 16 | Captured flag register read data |
| vecRead | output | 4 | Captured interrupt vector read data |

## Verification
Both flags, the data registers and the two captured read-backs change at the first rising edge after the cycle that carries the strobe. The bench therefore queues each expectation for that edge, and a monitor checks it 5 ns after the edge, while the inputs are still held. The interrupt requests follow the flags and the enables without a register, so their expectations share that same slot. `txLoad` and `txShiftData` depend on the inputs driven in the current cycle and would be gone by that sample point. They are checked 1 ns after the falling edge that drives the stimulus, before the edge that consumes it.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int FLAG_W = 16;
  localparam int RX_BIT = 9;
  localparam int TX_BIT = 8;
  localparam int VEC_W  = 4;
  localparam logic [VEC_W-1:0] VEC_NONE = 4'd0;
  localparam logic [VEC_W-1:0] VEC_RX   = 4'd1;
  localparam logic [VEC_W-1:0] VEC_TX   = 4'd2;

  typedef struct packed {
    logic hardClrRx;
    logic softClrRx;
    logic setRx;
    logic wrTx;
    logic loadTx;
    logic forceTx;
    logic capFlag;
    logic capVec;
  } sfcStrobe_t;
endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
(
  input  logic       swReset,
  input  logic       modReset,
  input  logic       wrTxStb,
  input  logic       wrFlagStb,
  input  logic       wrRxBit,
  input  logic       rdRxStb,
  input  logic       rdVecStb,
  input  logic       rdFlagStb,
  input  logic       rxByteDone,
  input  logic       shifterIdle,
  input  logic       txReady,
  output sfcStrobe_t stb
);
  always_comb begin
    stb.hardClrRx = swReset | modReset;
    stb.softClrRx = rdRxStb | (wrFlagStb & wrRxBit);
    stb.setRx     = rxByteDone;
    stb.wrTx      = wrTxStb;
    stb.loadTx    = shifterIdle & ~txReady & ~modReset;
    stb.forceTx   = modReset;
    stb.capFlag   = rdFlagStb;
    stb.capVec    = rdVecStb;
  end
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfcStrobe_t        stb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic              rxIntEn,
  input  logic              txIntEn,
  input  logic              txEnable,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txShiftData,
  output logic              rxReady,
  output logic              txReady,
  output logic              rxIrq,
  output logic              txIrq,
  output logic [FLAG_W-1:0] flagRead,
  output logic [VEC_W-1:0]  vecRead
);
  logic [FLAG_W-1:0] flagImage;
  logic [VEC_W-1:0]  vecCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxReady <= 1'b0;
    else if (stb.hardClrRx)   rxReady <= 1'b0;
    else if (stb.setRx)       rxReady <= 1'b1;
    else if (stb.softClrRx)   rxReady <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxData <= '0;
    else if (stb.setRx)    rxData <= rxByteIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txReady <= 1'b1;
    else if (stb.forceTx)  txReady <= 1'b1;
    else if (stb.wrTx)     txReady <= 1'b0;
    else if (stb.loadTx)   txReady <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShiftData <= '0;
    else if (stb.wrTx)     txShiftData <= wrByte;
  end

  assign rxIrq = rxReady & rxIntEn;
  assign txIrq = txReady & txIntEn & txEnable;

  always_comb begin
    flagImage         = '0;
    flagImage[RX_BIT] = rxReady;
    flagImage[TX_BIT] = txReady;
    if (rxIrq)      vecCode = VEC_RX;
    else if (txIrq) vecCode = VEC_TX;
    else            vecCode = VEC_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagRead <= '0;
      vecRead  <= VEC_NONE;
    end else begin
      if (stb.capFlag) flagRead <= flagImage;
      if (stb.capVec)  vecRead  <= vecCode;
    end
  end

  AST_RX_SET:    assert property (@(posedge clk) disable iff (!rstN)
                   stb.setRx && !stb.hardClrRx |=> rxReady);          // R1
  AST_RX_CLEAR:  assert property (@(posedge clk) disable iff (!rstN)
                   stb.hardClrRx |=> !rxReady);                       // R2
  AST_RX_HOLD:   assert property (@(posedge clk) disable iff (!rstN)
                   !stb.setRx && !stb.softClrRx && !stb.hardClrRx |=> $stable(rxReady)); // R3
  AST_TX_WRITE:  assert property (@(posedge clk) disable iff (!rstN)
                   stb.wrTx && !stb.forceTx |=> !txReady);            // R7
  AST_TX_LOAD:   assert property (@(posedge clk) disable iff (!rstN)
                   stb.loadTx && !stb.wrTx |=> txReady);              // R8
  AST_TX_FORCE:  assert property (@(posedge clk) disable iff (!rstN)
                   stb.forceTx |=> txReady);                          // R9
  AST_VEC_KEEP:  assert property (@(posedge clk) disable iff (!rstN)
                   stb.capVec && !stb.setRx && !stb.softClrRx && !stb.hardClrRx |=> $stable(rxReady)); // R5
endmodule

// File: rtl/serial_flag_ctrl.sv
module serial_flag_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              modReset,
  input  logic              txEnable,
  input  logic              rxIntEn,
  input  logic              txIntEn,
  input  logic              wrTxStb,
  input  logic              wrFlagStb,
  input  logic [FLAG_W-1:0] wrData,
  input  logic              rdRxStb,
  input  logic              rdVecStb,
  input  logic              rdFlagStb,
  input  logic              rxByteDone,
  input  logic [DATA_W-1:0] rxByteIn,
  input  logic              shifterIdle,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txShiftData,
  output logic              txLoad,
  output logic              rxReady,
  output logic              txReady,
  output logic              rxIrq,
  output logic              txIrq,
  output logic [FLAG_W-1:0] flagRead,
  output logic [VEC_W-1:0]  vecRead
);
  sfcStrobe_t stb;
  logic       unusedWrBits;

  assign unusedWrBits = ^{wrData[FLAG_W-1:RX_BIT+1], wrData[TX_BIT:DATA_W]};
  assign txLoad       = stb.loadTx;

  sfc_ctrl u_ctrl (
    .swReset     (swReset),
    .modReset    (modReset),
    .wrTxStb     (wrTxStb),
    .wrFlagStb   (wrFlagStb),
    .wrRxBit     (wrData[RX_BIT]),
    .rdRxStb     (rdRxStb),
    .rdVecStb    (rdVecStb),
    .rdFlagStb   (rdFlagStb),
    .rxByteDone  (rxByteDone),
    .shifterIdle (shifterIdle),
    .txReady     (txReady),
    .stb         (stb)
  );

  sfc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrByte      (wrData[DATA_W-1:0]),
    .rxByteIn    (rxByteIn),
    .rxIntEn     (rxIntEn),
    .txIntEn     (txIntEn),
    .txEnable    (txEnable),
    .rxData      (rxData),
    .txShiftData (txShiftData),
    .rxReady     (rxReady),
    .txReady     (txReady),
    .rxIrq       (rxIrq),
    .txIrq       (txIrq),
    .flagRead    (flagRead),
    .vecRead     (vecRead)
  );

  AST_IRQ_RX:  assert property (@(posedge clk) disable iff (!rstN)
                 rxIrq |-> rxReady && rxIntEn);                      // R6
  AST_IRQ_TX:  assert property (@(posedge clk) disable iff (!rstN)
                 txIrq |-> txReady && txEnable);                     // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
                 $countones(flagRead) <= 2);                         // R11
endmodule

// File: tb/serial_flag_ctrl_tb.sv
module serial_flag_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 0, modReset = 0, txEnable = 0, rxIntEn = 0, txIntEn = 0;
  logic        wrTxStb = 0, wrFlagStb = 0, rdRxStb = 0, rdVecStb = 0, rdFlagStb = 0;
  logic        rxByteDone = 0, shifterIdle = 0;
  logic [15:0] wrData = '0;
  logic [7:0]  rxByteIn = '0;
  logic [7:0]  rxData, txShiftData;
  logic        txLoad, rxReady, txReady, rxIrq, txIrq;
  logic [15:0] flagRead;
  logic [3:0]  vecRead;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    int          sel;
    logic [15:0] exp;
    string       req;
  } expItem_t;
  expItem_t sb[$];

  always #10 clk = ~clk;

  serial_flag_ctrl u_dut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .modReset(modReset),
    .txEnable(txEnable), .rxIntEn(rxIntEn), .txIntEn(txIntEn),
    .wrTxStb(wrTxStb), .wrFlagStb(wrFlagStb), .wrData(wrData),
    .rdRxStb(rdRxStb), .rdVecStb(rdVecStb), .rdFlagStb(rdFlagStb),
    .rxByteDone(rxByteDone), .rxByteIn(rxByteIn), .shifterIdle(shifterIdle),
    .rxData(rxData), .txShiftData(txShiftData), .txLoad(txLoad),
    .rxReady(rxReady), .txReady(txReady), .rxIrq(rxIrq), .txIrq(txIrq),
    .flagRead(flagRead), .vecRead(vecRead)
  );

  localparam int S_RXRDY = 0, S_TXRDY = 1, S_RXIRQ = 2, S_TXIRQ = 3, S_FLAG = 4,
                 S_VEC = 5, S_RXDATA = 6, S_TXLOAD = 7, S_TXDATA = 8;

  function automatic logic [15:0] sample(int sel);
    case (sel)
      S_RXRDY:  return {15'd0, rxReady};
      S_TXRDY:  return {15'd0, txReady};
      S_RXIRQ:  return {15'd0, rxIrq};
      S_TXIRQ:  return {15'd0, txIrq};
      S_FLAG:   return flagRead;
      S_VEC:    return {12'd0, vecRead};
      S_RXDATA: return {8'd0, rxData};
      S_TXLOAD: return {15'd0, txLoad};
      default:  return {8'd0, txShiftData};
    endcase
  endfunction

  task automatic compare(int sel, logic [15:0] exp, string req);
    logic [15:0] got;
    got = sample(sel);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%h expected=%h at cycle %0d", req, sel, got, exp, cyc);
    end
  endtask

  // driver side: expected value due after the coming rising edge
  task automatic expect_next(int sel, logic [15:0] exp, string req);
    expItem_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // combinational result of the inputs just driven
  task automatic check_now(int sel, logic [15:0] exp, string req);
    #1;
    compare(sel, exp, req);
  endtask

  task automatic step();
    @(negedge clk);
    swReset = 0; modReset = 0; wrTxStb = 0; wrFlagStb = 0; rdRxStb = 0;
    rdVecStb = 0; rdFlagStb = 0; rxByteDone = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        expItem_t it;
        it = sb.pop_front();
        compare(it.sel, it.exp, it.req);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    expect_next(S_RXRDY, 0, "R9 reset rx");
    expect_next(S_TXRDY, 1, "R9 reset tx");
    expect_next(S_FLAG, 0, "R11 reset");
    expect_next(S_VEC, 0, "R5 reset");
    // R1 byte arrives
    step(); rxByteDone = 1; rxByteIn = 8'hA5;
    expect_next(S_RXRDY, 1, "R1");
    expect_next(S_RXDATA, 16'h00A5, "R1");
    // R6 enable receive interrupt
    step(); rxIntEn = 1;
    expect_next(S_RXIRQ, 1, "R6");
    // R5 vector read keeps flag
    step(); rdVecStb = 1;
    expect_next(S_RXRDY, 1, "R5");
    expect_next(S_VEC, 1, "R5 rx code");
    // R3 write 0 to bit 9, 1 elsewhere
    step(); wrFlagStb = 1; wrData = 16'hFDFF;
    expect_next(S_RXRDY, 1, "R3");
    expect_next(S_TXRDY, 1, "R3");
    // R11 flag read
    step(); rdFlagStb = 1;
    expect_next(S_FLAG, 16'h0300, "R11");
    // R2 write-one clear
    step(); wrFlagStb = 1; wrData = 16'h0200;
    expect_next(S_RXRDY, 0, "R2 w1c");
    expect_next(S_RXIRQ, 0, "R6");
    // R4 set beats write-one clear
    step(); wrFlagStb = 1; wrData = 16'h0200; rxByteDone = 1; rxByteIn = 8'h3C;
    expect_next(S_RXRDY, 1, "R4 w1c");
    expect_next(S_RXDATA, 16'h003C, "R1");
    // R4 set beats read
    step(); rdRxStb = 1; rxByteDone = 1; rxByteIn = 8'h77;
    expect_next(S_RXRDY, 1, "R4 read");
    // R2 read clears
    step(); rdRxStb = 1;
    expect_next(S_RXRDY, 0, "R2 read");
    step(); rxByteDone = 1; rxByteIn = 8'h11;
    expect_next(S_RXRDY, 1, "R1");
    // R2 software reset
    step(); swReset = 1;
    expect_next(S_RXRDY, 0, "R2 swReset");
    expect_next(S_TXRDY, 1, "R9");
    // R4 module reset beats set
    step(); modReset = 1; rxByteDone = 1;
    expect_next(S_RXRDY, 0, "R4 reset");
    // R10 transmit interrupt
    step(); txIntEn = 1; txEnable = 1;
    expect_next(S_TXIRQ, 1, "R10");
    step(); rdVecStb = 1;
    expect_next(S_VEC, 2, "R5 tx code");
    expect_next(S_TXRDY, 1, "R5");
    // R7 write transmit data
    step(); wrTxStb = 1; wrData = 16'h005A;
    expect_next(S_TXRDY, 0, "R7");
    expect_next(S_TXIRQ, 0, "R10");
    expect_next(S_TXDATA, 16'h005A, "R7");
    // R8 copy to shifter
    step(); shifterIdle = 1;
    check_now(S_TXLOAD, 1, "R8");
    check_now(S_TXDATA, 16'h005A, "R8");
    expect_next(S_TXRDY, 1, "R8");
    expect_next(S_TXIRQ, 1, "R10");
    step();
    check_now(S_TXLOAD, 0, "R8 full");
    // R8 write on copy cycle wins
    step(); wrTxStb = 1; wrData = 16'h0081;
    expect_next(S_TXRDY, 0, "R7");
    step(); wrTxStb = 1; wrData = 16'h0042;
    check_now(S_TXLOAD, 1, "R8");
    check_now(S_TXDATA, 16'h0081, "R8");
    expect_next(S_TXRDY, 0, "R8 write wins");
    expect_next(S_TXDATA, 16'h0042, "R8 write wins");
    step();
    expect_next(S_TXRDY, 1, "R8");
    // R10 transmitter disabled
    step(); shifterIdle = 0; txEnable = 0;
    expect_next(S_TXIRQ, 0, "R10 txEnable");
    step(); txEnable = 1; txIntEn = 0;
    expect_next(S_TXIRQ, 0, "R10 txIntEn");
    // R9 swReset does not fill, modReset does
    step(); txIntEn = 1; wrTxStb = 1; wrData = 16'h0099;
    expect_next(S_TXRDY, 0, "R7");
    step(); swReset = 1;
    expect_next(S_TXRDY, 0, "R9 swReset");
    step(); modReset = 1; shifterIdle = 1;
    check_now(S_TXLOAD, 0, "R8 modReset");
    expect_next(S_TXRDY, 1, "R9 modReset");
    // R9 modReset beats write
    step(); shifterIdle = 0; modReset = 1; wrTxStb = 1; wrData = 16'h0010;
    expect_next(S_TXRDY, 1, "R9 over write");
    // R3 bit 8 write ignored
    step(); wrTxStb = 1; wrData = 16'h0010;
    expect_next(S_TXRDY, 0, "R7");
    step(); wrFlagStb = 1; wrData = 16'hFDFF;
    expect_next(S_TXRDY, 0, "R3 bit8");
    expect_next(S_RXRDY, 0, "R3");
    step(); rdFlagStb = 1;
    expect_next(S_FLAG, 16'h0000, "R11");
    step(); step(); step();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule